// File: doc/BRIEF.md
# Accumulator Literal and Register-Bit Execute Stage

This block is the execute stage of a small 8-bit accumulator controller whose instructions are 13 bits wide. It covers two instruction families. The first combines an 8-bit immediate with the accumulator: load, OR, AND, XOR, add, and a reversed subtract that computes the immediate minus the accumulator. The second works on one register selected from a 64-entry file: clear a bit, set a bit, skip on a bit's value, and increment with a skip when the result is zero.

The register file is read combinationally through the `rf_addr`/`rf_rdata` pair. A write request (`rf_wen`, `rf_wdata`) is issued in the same cycle, and the file takes it on the next rising edge. The accumulator and the zero (Z), carry (C) and half-carry (DC) flags are held inside the block. Each instruction updates only the flags that belong to it. The sequencer receives `skip_req` during the execute cycle. It then discards the next instruction, so a skip that is taken costs two cycles and one that is not taken costs one.

Top module: `lbx_exec`

## Requirements
- R1: After reset the accumulator and Z, C, DC are 0. While `instr_valid` is low, `rf_wen` and `skip_req` are 0.
- R2: Load-immediate (`instr[12:8]` = 5'b11000) puts `instr[7:0]` in the accumulator and leaves all flags unchanged.
- R3: OR, AND and XOR with the immediate (`instr[12:8]` = 11001, 11010, 11011) write the result to the accumulator. They set Z when the result is zero and leave C and DC unchanged.
- R4: Add (`instr[12:8]` = 11111) writes immediate plus accumulator, mod 256. C is the carry out of bit 7 and DC is the carry out of bit 3. Z is set when the result is zero.
- R5: Subtract (`instr[12:8]` = 11101) writes immediate minus accumulator. C is 1 when no borrow occurs, DC is 1 when the low nibble has no borrow, and Z is set when the result is zero.
- R6: Bit clear and bit set (`instr[12:9]` = 0100 and 0101, bit index `instr[8:6]`) write the register back with only that bit changed. They raise no skip and change no flag.
- R7: Skip-if-clear (`instr[12:9]` = 0110) and skip-if-set (`instr[12:9]` = 0111) raise `skip_req` when the selected bit matches the condition. They write nothing and change no flag.
- R8: Increment-skip (`instr[12:6]` = 7'b0011111) writes the register plus 1, mod 256. It raises `skip_req` when the written value is zero and changes no flag.
- R9: Any other encoding, or any instruction while `instr_valid` is low, leaves the accumulator and the flags unchanged and raises neither a write nor a skip.
- R10: For the register-family operations, `rf_addr` equals `instr[5:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | The instruction on `instr` executes this cycle |
| instr | input | 13 | Instruction word |
| rf_rdata | input | 8 | Read data for the register at `rf_addr` |
| rf_addr | output | 6 | Register address |
| rf_wen | output | 1 | Register write request |
| rf_wdata | output | 8 | Register write data |
| skip_req | output | 1 | Request to discard the next instruction |
| acc | output | 8 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_dc | output | 1 | Half-carry / half no-borrow flag |

## Verification
The checker assumes two things about the inputs. The first is that `rf_rdata` is stable, and belongs to the addressed register, for the whole cycle in which a register-family instruction executes. The second is that `instr` does not change between a clock edge and the end of that cycle, so that `$past` of the instruction fields describes the operation that produced the current accumulator. The bench keeps to both. It drives `instr`, `instr_valid` and `rf_rdata` only on falling edges and holds them until after the next rising edge. It also supplies the read data directly, in place of a modelled register file, so that every value a bit operation sees is known in advance.

// File: rtl/lbx_pkg.sv
package lbx_pkg;
   typedef enum logic [3:0] {
      OP_NOP,
      OP_MOV,
      OP_OR,
      OP_AND,
      OP_XOR,
      OP_ADD,
      OP_SUB,
      OP_BCLR,
      OP_BSET,
      OP_SKCLR,
      OP_SKSET,
      OP_INCSZ
   } lbx_op_e;
endpackage

// File: rtl/lbx_decode.sv
module lbx_decode
   import lbx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int IW     = DATA_W + 5
) (
   input  logic          valid_i,
   input  logic [IW-1:0] instr_i,
   output lbx_op_e       op_o
);
   localparam int PFX_W = IW - ADDR_W;
   localparam logic [PFX_W-1:0] INC_PFX = {2'b00, {(PFX_W-2){1'b1}}};

   always_comb begin
      op_o = OP_NOP;
      if (valid_i) begin
         if (instr_i[IW-1:IW-2] == 2'b11) begin
            unique case (instr_i[IW-3:DATA_W])
               3'b000:  op_o = OP_MOV;
               3'b001:  op_o = OP_OR;
               3'b010:  op_o = OP_AND;
               3'b011:  op_o = OP_XOR;
               3'b101:  op_o = OP_SUB;
               3'b111:  op_o = OP_ADD;
               default: op_o = OP_NOP;
            endcase
         end else if (instr_i[IW-1:IW-2] == 2'b01) begin
            unique case (instr_i[IW-3:IW-4])
               2'b00:   op_o = OP_BCLR;
               2'b01:   op_o = OP_BSET;
               2'b10:   op_o = OP_SKCLR;
               default: op_o = OP_SKSET;
            endcase
         end else if (instr_i[IW-1:ADDR_W] == INC_PFX) begin
            op_o = OP_INCSZ;
         end
      end
   end
endmodule

// File: rtl/lbx_arith.sv
module lbx_arith #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] lit_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              dc_o
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] opnd;
   logic [DATA_W:0]   full_sum;
   logic [HALF_W:0]   half_sum;

   // Subtraction lit - acc is lit + ~acc + 1; carry out means no borrow.
   always_comb begin
      opnd     = sub_i ? ~acc_i : acc_i;
      full_sum = {1'b0, lit_i} + {1'b0, opnd} + {{DATA_W{1'b0}}, sub_i};
      half_sum = {1'b0, lit_i[HALF_W-1:0]} + {1'b0, opnd[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, sub_i};
      res_o    = full_sum[DATA_W-1:0];
      c_o      = full_sum[DATA_W];
      dc_o     = half_sum[HALF_W];
   end
endmodule

// File: rtl/lbx_bitunit.sv
module lbx_bitunit
   import lbx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BIDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [BIDX_W-1:0] idx_i,
   input  lbx_op_e           op_i,
   output logic [DATA_W-1:0] wdata_o,
   output logic              bit_o
);
   logic [DATA_W-1:0] mask;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (idx_i == BIDX_W'(i));
   end

   assign bit_o = |(rdata_i & mask);

   always_comb begin
      unique case (op_i)
         OP_BCLR:  wdata_o = rdata_i & ~mask;
         OP_BSET:  wdata_o = rdata_i | mask;
         OP_INCSZ: wdata_o = rdata_i + DATA_W'(1);
         default:  wdata_o = rdata_i;
      endcase
   end
endmodule

// File: rtl/lbx_exec.sv
module lbx_exec
   import lbx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   localparam int BIDX_W = $clog2(DATA_W),
   localparam int IW     = DATA_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [IW-1:0]     instr,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic [ADDR_W-1:0] rf_addr,
   output logic              rf_wen,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              skip_req,
   output logic [DATA_W-1:0] acc,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_dc
);
   if (DATA_W != (1 << BIDX_W) || DATA_W < 4) begin : g_bad_data_w
      $error("lbx_exec: DATA_W must be a power of two of at least 4");
   end
   if (IW != 4 + BIDX_W + ADDR_W) begin : g_bad_layout
      $error("lbx_exec: bit-group fields do not fill the instruction word");
   end

   lbx_op_e           op;
   logic [DATA_W-1:0] lit;
   logic [BIDX_W-1:0] bidx;
   logic [DATA_W-1:0] ar_res;
   logic              ar_c, ar_dc;
   logic              sel_bit;
   logic [DATA_W-1:0] acc_q, acc_d;
   logic              z_q, c_q, dc_q, z_d, c_d, dc_d;

   assign lit     = instr[DATA_W-1:0];
   assign bidx    = instr[ADDR_W+BIDX_W-1:ADDR_W];
   assign rf_addr = instr[ADDR_W-1:0];

   lbx_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IW(IW)) u_dec (
      .valid_i (instr_valid),
      .instr_i (instr),
      .op_o    (op)
   );

   lbx_arith #(.DATA_W(DATA_W)) u_arith (
      .lit_i (lit),
      .acc_i (acc_q),
      .sub_i (op == OP_SUB),
      .res_o (ar_res),
      .c_o   (ar_c),
      .dc_o  (ar_dc)
   );

   lbx_bitunit #(.DATA_W(DATA_W), .BIDX_W(BIDX_W)) u_bit (
      .rdata_i (rf_rdata),
      .idx_i   (bidx),
      .op_i    (op),
      .wdata_o (rf_wdata),
      .bit_o   (sel_bit)
   );

   always_comb begin
      acc_d = acc_q;
      z_d   = z_q;
      c_d   = c_q;
      dc_d  = dc_q;
      unique case (op)
         OP_MOV: acc_d = lit;
         OP_OR:  begin acc_d = acc_q | lit; z_d = ~|acc_d; end
         OP_AND: begin acc_d = acc_q & lit; z_d = ~|acc_d; end
         OP_XOR: begin acc_d = acc_q ^ lit; z_d = ~|acc_d; end
         OP_ADD, OP_SUB: begin
            acc_d = ar_res;
            z_d   = ~|ar_res;
            c_d   = ar_c;
            dc_d  = ar_dc;
         end
         default: ;
      endcase
   end

   assign rf_wen   = (op == OP_BCLR) || (op == OP_BSET) || (op == OP_INCSZ);
   assign skip_req = ((op == OP_SKCLR) && !sel_bit)
                  || ((op == OP_SKSET) && sel_bit)
                  || ((op == OP_INCSZ) && (rf_wdata == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         z_q   <= 1'b0;
         c_q   <= 1'b0;
         dc_q  <= 1'b0;
      end else begin
         acc_q <= acc_d;
         z_q   <= z_d;
         c_q   <= c_d;
         dc_q  <= dc_d;
      end
   end

   assign acc     = acc_q;
   assign flag_z  = z_q;
   assign flag_c  = c_q;
   assign flag_dc = dc_q;
endmodule

// File: rtl/lbx_exec_chk.sv
module lbx_exec_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int IW     = DATA_W + 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [IW-1:0]     instr,
   input logic [DATA_W-1:0] rf_rdata,
   input logic [ADDR_W-1:0] rf_addr,
   input logic              rf_wen,
   input logic [DATA_W-1:0] rf_wdata,
   input logic              skip_req,
   input logic [DATA_W-1:0] acc,
   input logic              flag_z,
   input logic              flag_c,
   input logic              flag_dc
);
   logic [4:0] top5;
   logic       is_mov, is_add, is_bitw, is_inc, is_test, is_nop;

   assign top5    = instr[IW-1:IW-5];
   assign is_mov  = instr_valid && top5 == 5'b11000;
   assign is_add  = instr_valid && top5 == 5'b11111;
   assign is_bitw = instr_valid && instr[IW-1:IW-3] == 3'b010;
   assign is_test = instr_valid && instr[IW-1:IW-3] == 3'b011;
   assign is_inc  = instr_valid && instr[IW-1:IW-5] == 5'b00111
                                && instr[IW-6:ADDR_W] == '1;
   assign is_nop  = !instr_valid || (!instr[IW-2] && !is_inc)
                 || top5 == 5'b11100 || top5 == 5'b11110;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> !rf_wen && !skip_req); // R1

   AST_MOV_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      is_mov |=> {flag_z, flag_c, flag_dc} == $past({flag_z, flag_c, flag_dc})); // R2

   AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      is_add |=> acc == DATA_W'($past(instr[DATA_W-1:0]) + $past(acc))); // R4

   AST_BITW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      is_bitw |-> rf_wen && !skip_req && $countones(rf_wdata ^ rf_rdata) <= 1); // R6

   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      is_test |-> !rf_wen); // R7

   AST_INC_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      is_inc |-> rf_wen && (skip_req == (rf_wdata == '0))); // R8

   AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      is_nop |=> $stable(acc) && $stable({flag_z, flag_c, flag_dc})); // R9

   AST_ADDR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (is_bitw || is_test || is_inc) |-> rf_addr == instr[ADDR_W-1:0]); // R10
endmodule

bind lbx_exec lbx_exec_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IW(IW)) u_chk (.*);

// File: tb/lbx_exec_tb.sv
module lbx_exec_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [3:0]  req;
      logic [12:0] ins;
      logic [7:0]  rd;
      logic [7:0]  acc;
      logic [2:0]  zcd;
      logic        wen;
      logic [7:0]  wd;
      logic        skip;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{4'd2, 13'h183C, 8'h00, 8'h3C, 3'b000, 1'b0, 8'h00, 1'b0}, // R2 load
      '{4'd4, 13'h1F0F, 8'h00, 8'h4B, 3'b001, 1'b0, 8'h00, 1'b0}, // R4 half carry only
      '{4'd4, 13'h1FB5, 8'h00, 8'h00, 3'b111, 1'b0, 8'h00, 1'b0}, // R4 wrap to zero
      '{4'd2, 13'h1880, 8'h00, 8'h80, 3'b111, 1'b0, 8'h00, 1'b0}, // R2 flags kept
      '{4'd4, 13'h1F80, 8'h00, 8'h00, 3'b110, 1'b0, 8'h00, 1'b0}, // R4 carry, no half
      '{4'd2, 13'h1810, 8'h00, 8'h10, 3'b110, 1'b0, 8'h00, 1'b0}, // R2
      '{4'd5, 13'h1D25, 8'h00, 8'h15, 3'b011, 1'b0, 8'h00, 1'b0}, // R5 no borrow
      '{4'd5, 13'h1D05, 8'h00, 8'hF0, 3'b001, 1'b0, 8'h00, 1'b0}, // R5 borrow
      '{4'd5, 13'h1DF0, 8'h00, 8'h00, 3'b111, 1'b0, 8'h00, 1'b0}, // R5 equal
      '{4'd2, 13'h185A, 8'h00, 8'h5A, 3'b111, 1'b0, 8'h00, 1'b0}, // R2
      '{4'd3, 13'h1981, 8'h00, 8'hDB, 3'b011, 1'b0, 8'h00, 1'b0}, // R3 or
      '{4'd3, 13'h1A24, 8'h00, 8'h00, 3'b111, 1'b0, 8'h00, 1'b0}, // R3 and
      '{4'd3, 13'h1BFF, 8'h00, 8'hFF, 3'b011, 1'b0, 8'h00, 1'b0}, // R3 xor
      '{4'd5, 13'h1D00, 8'h00, 8'h01, 3'b000, 1'b0, 8'h00, 1'b0}, // R5 both borrows
      '{4'd6, 13'h08EA, 8'hFF, 8'h01, 3'b000, 1'b1, 8'hF7, 1'b0}, // R6 clear bit 3
      '{4'd6, 13'h0BD5, 8'h00, 8'h01, 3'b000, 1'b1, 8'h80, 1'b0}, // R6 set bit 7
      '{4'd7, 13'h0C01, 8'hFE, 8'h01, 3'b000, 1'b0, 8'h00, 1'b1}, // R7 clear -> skip
      '{4'd7, 13'h0C01, 8'h01, 8'h01, 3'b000, 1'b0, 8'h00, 1'b0}, // R7
      '{4'd7, 13'h0F7F, 8'h20, 8'h01, 3'b000, 1'b0, 8'h00, 1'b1}, // R7 set -> skip
      '{4'd7, 13'h0F7F, 8'hDF, 8'h01, 3'b000, 1'b0, 8'h00, 1'b0}, // R7
      '{4'd8, 13'h07FF, 8'hFF, 8'h01, 3'b000, 1'b1, 8'h00, 1'b1}, // R8 wrap skip
      '{4'd8, 13'h07C0, 8'h41, 8'h01, 3'b000, 1'b1, 8'h42, 1'b0}, // R8
      '{4'd9, 13'h1E01, 8'h00, 8'h01, 3'b000, 1'b0, 8'h00, 1'b0}, // R9
      '{4'd9, 13'h1C55, 8'h00, 8'h01, 3'b000, 1'b0, 8'h00, 1'b0}, // R9
      '{4'd9, 13'h0000, 8'h00, 8'h01, 3'b000, 1'b0, 8'h00, 1'b0}, // R9
      '{4'd9, 13'h1400, 8'h00, 8'h01, 3'b000, 1'b0, 8'h00, 1'b0}  // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [12:0] instr = '0;
   logic [7:0]  rf_rdata = '0;
   logic [5:0]  rf_addr;
   logic        rf_wen, skip_req, flag_z, flag_c, flag_dc;
   logic [7:0]  rf_wdata, acc;
   int          nchk = 0;
   int          nfail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lbx_exec u_dut (.*);

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Drive on a falling edge, check combinational outputs, let one rising edge pass.
   task automatic step(logic v, logic [12:0] ins, logic [7:0] rd);
      @(negedge clk);
      instr_valid = v;
      instr       = ins;
      rf_rdata    = rd;
      #1;
   endtask

   task automatic finish_step();
      @(posedge clk);
      #1 instr_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "acc at reset", acc, 8'h00);
      chk("R1", "flags at reset", {flag_z, flag_c, flag_dc}, 3'b000);
      rst_n = 1'b1;
      step(1'b0, 13'h0BD5, 8'h00);
      chk("R1", "idle wen", rf_wen, 1'b0);
      chk("R1", "idle skip", skip_req, 1'b0);
      finish_step();

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         step(1'b1, VECS[i].ins, VECS[i].rd);
         chk(tag, "rf_wen", rf_wen, VECS[i].wen);
         if (VECS[i].wen) chk(tag, "rf_wdata", rf_wdata, VECS[i].wd);
         chk(tag, "skip_req", skip_req, VECS[i].skip);
         finish_step();
         chk(tag, "acc", acc, VECS[i].acc);
         chk(tag, "zcd", {flag_z, flag_c, flag_dc}, VECS[i].zcd);
      end

      // R10 address field for register-family operations
      step(1'b1, 13'h0BD5, 8'h00);
      chk("R10", "rf_addr bit set", rf_addr, 6'h15);
      finish_step();
      step(1'b1, 13'h07FF, 8'h10);
      chk("R10", "rf_addr inc", rf_addr, 6'h3F);
      finish_step();

      // R9 invalid literal op must not touch accumulator (acc is 01 here)
      step(1'b0, 13'h18AA, 8'h00);
      chk("R9", "invalid wen", rf_wen, 1'b0);
      finish_step();
      chk("R9", "invalid acc", acc, 8'h01);

      // R1 reset in mid-run clears state
      step(1'b1, 13'h1F7F, 8'h00);
      finish_step();
      chk("R4", "add before reset", {acc, flag_z, flag_c, flag_dc}, {8'h80, 3'b001});
      rst_n = 1'b0;
      #1;
      chk("R1", "acc after reset", acc, 8'h00);
      chk("R1", "flags after reset", {flag_z, flag_c, flag_dc}, 3'b000);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule